// File: doc/BRIEF.md
# Multi-channel PWM controller with two-stage clock division

The block produces a set of pulse-width-modulated outputs, one per channel, each configured through a small word-addressed register interface. The time base for a channel is built in two stages. Two neighbouring channels share one clock setup word. That word picks the source, either a slow reference pulse or the bus clock itself, and applies a power-of-two divider. Each channel then divides again by its own linear factor and runs a period counter. Both clock sources are modelled as single-cycle enables in the bus clock domain; no clock is actually switched.

A channel produces its active level while its counter is below a programmed active count. The period length and the active count are written into one word. That word, together with the linear prescale factor, is held in a shadow copy and only taken over when the running period ends. As a result, a period that is already under way always finishes with the settings it started with. A channel runs only while both its run bit and its gate bit are set. Output polarity takes effect at once.

Top module: `pwm_ctrl`

## Requirements
- R1: After reset every register reads zero and every output is high, because the polarity bit is 0 and all channels are stopped.
- R2: The clock setup word for channel c is at byte offset 0x20 + 4*(c>>1), so channels 2k and 2k+1 share it. Bit 7 set selects the bus clock, which ticks every cycle. Bit 7 clear selects the `ref_tick` input.
- R3: Bits [3:0] of the clock setup word hold an exponent M, and the selected source is divided by 2^M. A value above 8 acts as 8.
- R4: The channel control word is at 0x100 + 0x20*c. Bits [7:0] hold K, which divides the shared tick by K+1.
- R5: The channel span word is at 0x104 + 0x20*c. Bits [31:16] hold P, so the period is P+1 prescaled steps. Bits [15:0] hold the active count A. The channel is active while its counter, which runs from 0 to P, is below A.
- R6: A = 0 gives 0% active time. Any A > P gives 100% active time.
- R7: Offset 0x80 holds run bits and offset 0x40 holds gate bits, with bit c belonging to channel c. A channel counts only when both bits are 1. Otherwise its counter is held at 0 and its output sits at the inactive level.
- R8: Bit 8 of the control word set means the output is high while active. Bit 8 clear inverts the output. A change of this bit takes effect at once.
- R9: Writes to the span word and to K take effect only when the counter wraps from P to 0, or at once while the channel is stopped.
- R10: Unused bits read as 0. Writes to unmapped or misaligned offsets change nothing, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, which also serves as the fast counting source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_tick | input | 1 | One-cycle enable pulse standing for the reference clock |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word (combinational) |
| pwm_out | output | NCH | Channel outputs |

## Verification
The case that needs care is a register write that lands while a period is still running. The write fills the shadow copy in the same cycles that the counter keeps stepping through the old period. To provoke it, a running channel with P=9 and A=5 is given a new span word (P=3, A=1) two cycles after its output falls. The test then measures the lengths of the output runs that follow. The remaining inactive run must be 5 cycles, which shows the old period finished, and it must be followed by runs of exactly 1 cycle and 3 cycles under the new settings. If the new value were loaded immediately, the counter would already be past the new P and the inactive run would grow far beyond 5 cycles.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PRE_W   = 8;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned EXP_W   = 4;
  localparam int unsigned EXP_MAX = 8;

  localparam int unsigned OFS_CLK    = 32'h020;
  localparam int unsigned OFS_GATE   = 32'h040;
  localparam int unsigned OFS_RUN    = 32'h080;
  localparam int unsigned OFS_CTL    = 32'h100;
  localparam int unsigned OFS_SPAN   = 32'h104;
  localparam int unsigned CH_STRIDE  = 32'h020;

  typedef struct packed {
    logic             bus;
    logic [EXP_W-1:0] exp;
  } clkcfg_t;

  typedef struct packed {
    logic             pol;
    logic [PRE_W-1:0] div;
  } chctl_t;

  typedef struct packed {
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] act;
  } span_t;
endpackage

// File: rtl/pwm_pair_div.sv
module pwm_pair_div
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             use_bus,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = EXP_MAX;

  logic [DIV_W-1:0] cnt_q, cnt_d, mask;
  logic [EXP_W-1:0] exp_eff;
  logic             src;

  always_comb begin
    src     = use_bus ? 1'b1 : ref_tick;
    exp_eff = (exp_i > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_i;
    mask    = DIV_W'(({{DIV_W{1'b0}}, 1'b1} << exp_eff) - 1'b1);
    tick_o  = src && ((cnt_q & mask) == mask);
    cnt_d   = src ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: with any exponent above zero, two ticks never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && exp_eff != '0) |=> (!tick_o || exp_eff == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             pol,
  input  logic [PRE_W-1:0] div_sh,
  input  logic [CNT_W-1:0] last_sh,
  input  logic [CNT_W-1:0] act_sh,
  output logic             out
);
  logic [PRE_W-1:0] pre_q, pre_d, div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last_q, last_d, act_q, act_d;
  logic             step, wrap, active;

  always_comb begin
    step   = run && tick && (pre_q == div_q);
    wrap   = step && (cnt_q == last_q);
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    div_d  = div_q;
    last_d = last_q;
    act_d  = act_q;
    if (!run) begin
      pre_d  = '0;
      cnt_d  = '0;
      div_d  = div_sh;
      last_d = last_sh;
      act_d  = act_sh;
    end else if (tick) begin
      pre_d = (pre_q == div_q) ? '0 : pre_q + 1'b1;
      if (wrap) begin
        cnt_d  = '0;
        div_d  = div_sh;
        last_d = last_sh;
        act_d  = act_sh;
      end else if (step) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    active = run && (cnt_q < act_q);
    out    = pol ? active : !active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      div_q  <= '0;
      last_q <= '0;
      act_q  <= '0;
    end else begin
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      last_q <= last_d;
      act_q  <= act_d;
    end
  end

  // R7: a stopped channel has its counter at zero one cycle later
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
  // R5: a running counter never passes the working period value
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last_q));
  // R9: working period only changes at a wrap or while stopped
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(last_q));
  // R6: zero active count keeps the output at its inactive level
  p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == '0) |-> (out == !pol));
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int unsigned NPAIR = (NCH + 1) / 2;

  logic [1:0]     rst_pipe;
  logic           rst_n_s;
  clkcfg_t        cfg_q  [NPAIR];
  clkcfg_t        cfg_d  [NPAIR];
  chctl_t         ctl_q  [NCH];
  chctl_t         ctl_d  [NCH];
  span_t          span_q [NCH];
  span_t          span_d [NCH];
  logic [NCH-1:0] run_q, run_d, gate_q, gate_d, ch_run;
  logic [NPAIR-1:0] pair_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  always_comb begin
    cfg_d  = cfg_q;
    ctl_d  = ctl_q;
    span_d = span_q;
    run_d  = run_q;
    gate_d = gate_q;
    rdata  = '0;
    for (int p = 0; p < NPAIR; p++) begin
      if (addr == ADDR_W'(OFS_CLK + 4 * p)) begin
        rdata = {24'b0, cfg_q[p].bus, 3'b0, cfg_q[p].exp};
        if (wr_en) cfg_d[p] = {wdata[7], wdata[EXP_W-1:0]};
      end
    end
    if (addr == ADDR_W'(OFS_GATE)) begin
      rdata = 32'(gate_q);
      if (wr_en) gate_d = wdata[NCH-1:0];
    end
    if (addr == ADDR_W'(OFS_RUN)) begin
      rdata = 32'(run_q);
      if (wr_en) run_d = wdata[NCH-1:0];
    end
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(OFS_CTL + CH_STRIDE * c)) begin
        rdata = 32'(ctl_q[c]);
        if (wr_en) ctl_d[c] = wdata[PRE_W:0];
      end
      if (addr == ADDR_W'(OFS_SPAN + CH_STRIDE * c)) begin
        rdata = span_q[c];
        if (wr_en) span_d[c] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      for (int p = 0; p < NPAIR; p++) cfg_q[p] <= '0;
      for (int c = 0; c < NCH; c++) begin
        ctl_q[c]  <= '0;
        span_q[c] <= '0;
      end
      run_q  <= '0;
      gate_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      ctl_q  <= ctl_d;
      span_q <= span_d;
      run_q  <= run_d;
      gate_q <= gate_d;
    end
  end

  assign ch_run = run_q & gate_q;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm_pair_div u_div (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .ref_tick (ref_tick),
      .use_bus  (cfg_q[p].bus),
      .exp_i    (cfg_q[p].exp),
      .tick_o   (pair_tick[p])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .run     (ch_run[c]),
      .tick    (pair_tick[c/2]),
      .pol     (ctl_q[c].pol),
      .div_sh  (ctl_q[c].div),
      .last_sh (span_q[c].last),
      .act_sh  (span_q[c].act),
      .out     (pwm_out[c])
    );

    // R7: a channel missing its run or gate bit shows the inactive level
    p_stopped_level_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
      !ch_run[c] |-> (pwm_out[c] == !ctl_q[c].pol));
  end
endmodule

// File: tb/tb_pwm_ctrl.sv
module tb_pwm_ctrl;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick;
  logic        wr_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  pwm_out;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  pwm_ctrl #(.NCH(NCH), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  initial begin
    ref_tick = 1'b0;
    forever begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
      @(negedge clk);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic stop_all();
    wr(12'h080, 0);
    wr(12'h040, 0);
  endtask

  task automatic start(input int mask);
    wr(12'h040, mask);
    wr(12'h080, mask);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  task automatic duty_case(input string req, input logic [31:0] cfg, input logic [31:0] ctl,
                           input int p, input int a, input int ch, input int win, input int exp_hi);
    int hi;
    stop_all();
    wr(12'h020, cfg);
    wr(12'(32'h100 + 32'h20 * ch), ctl);
    wr(12'(32'h104 + 32'h20 * ch), {p[15:0], a[15:0]});
    start(1 << ch);
    repeat (3) @(negedge clk);
    count_high(ch, win, hi);
    chk(hi == exp_hi, req, hi, exp_hi);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h020, d); chk(d == 0, "R1 clk word", d, 0);
    rd(12'h100, d); chk(d == 0, "R1 ctl word", d, 0);
    rd(12'h104, d); chk(d == 0, "R1 span word", d, 0);
    chk(pwm_out == 2'b11, "R1 outputs", pwm_out, 3);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(12'h100, 32'hFFFF_FFFF); rd(12'h100, d); chk(d == 32'h1FF, "R4 R10 ctl bits", d, 32'h1FF);
    wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, d); chk(d == 32'h8F, "R2 R10 clk bits", d, 32'h8F);
    wr(12'h124, 32'hDEAD_BEEF); rd(12'h124, d); chk(d == 32'hDEAD_BEEF, "R5 span ch1", d, 32'hDEAD_BEEF);
    wr(12'h080, 32'hFFFF_FFFF); rd(12'h080, d); chk(d == 3, "R7 run bits", d, 3);
    wr(12'h084, 32'h5); rd(12'h080, d); chk(d == 3, "R10 unmapped write", d, 3);
    rd(12'h084, d); chk(d == 0, "R10 unmapped read", d, 0);
    wr(12'h082, 32'h0); rd(12'h080, d); chk(d == 3, "R10 misaligned write", d, 3);
    wr(12'h080, 0); wr(12'h100, 0); wr(12'h020, 0); wr(12'h124, 0);
  endtask

  task automatic t_stopped();
    int hi;
    stop_all();
    wr(12'h020, 32'h80);
    wr(12'h100, 32'h100);
    wr(12'h104, {16'd3, 16'd2});
    wr(12'h080, 1);
    count_high(0, 20, hi);
    chk(hi == 0, "R7 gate clear", hi, 0);
    wr(12'h080, 0); wr(12'h040, 1);
    count_high(0, 20, hi);
    chk(hi == 0, "R7 run clear", hi, 0);
    wr(12'h100, 32'h000);
    @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R7 R8 idle inverted", pwm_out[0], 1);
  endtask

  task automatic t_shadow();
    int lo, hi2, lo2;
    stop_all();
    wr(12'h020, 32'h80);
    wr(12'h100, 32'h100);
    wr(12'h104, {16'd9, 16'd5});
    start(1);
    while (pwm_out[0] == 1'b0) @(negedge clk);
    while (pwm_out[0] == 1'b1) @(negedge clk);
    lo = 1;
    wr(12'h104, {16'd3, 16'd1});
    while (pwm_out[0] == 1'b0 && lo < 40) begin lo++; @(negedge clk); end
    hi2 = 0;
    while (pwm_out[0] == 1'b1 && hi2 < 40) begin hi2++; @(negedge clk); end
    lo2 = 0;
    while (pwm_out[0] == 1'b0 && lo2 < 40) begin lo2++; @(negedge clk); end
    chk(lo == 5, "R9 old period completes", lo, 5);
    chk(hi2 == 1, "R9 new active run", hi2, 1);
    chk(lo2 == 3, "R9 new inactive run", lo2, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    duty_case("R5 basic",          32'h80, 32'h100, 9, 3, 0,   40,  12);
    duty_case("R4 prescale",       32'h80, 32'h102, 3, 2, 0,   48,  24);
    duty_case("R3 divide by 4",    32'h82, 32'h100, 4, 1, 0,   80,  16);
    duty_case("R3 exponent clamp", 32'h8C, 32'h100, 1, 1, 0, 1024, 512);
    duty_case("R2 reference src",  32'h01, 32'h100, 1, 1, 0,   48,  24);
    duty_case("R2 shared pair ch1",32'h81, 32'h100, 1, 1, 1,   16,   8);
    duty_case("R6 zero duty",      32'h80, 32'h100, 5, 0, 0,   24,   0);
    duty_case("R6 full duty",      32'h80, 32'h100, 5, 7, 0,   24,  24);
    duty_case("R8 inverted",       32'h80, 32'h000, 3, 1, 0,   16,  12);
    t_stopped();
    t_shadow();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule